// File: doc/BRIEF.md
# Dual-Mode Pixel Input Capture

This block takes a parallel video interface clocked by an external data clock: one or two 24-bit pixel buses, a data-enable, horizontal and vertical sync and three general-purpose control bits. A static strap picks whether every input is latched on the rising or the falling edge of that clock. A second strap picks one pixel per input clock, taken from the even bus, or two pixels per input clock, with the even bus carrying the first pixel and the odd bus the second.

Captured values are registered in the input-clock domain and then handed to an output pixel clock through a two-entry holding register. In single-pixel mode the pixel clock runs at the input rate. In two-pixel mode it runs at exactly twice the input rate, and the block emits the even pixel followed by the odd pixel on consecutive pixel clocks. The enable, sync and control values captured with a pair appear unchanged on both pixels. An active-low power-down input freezes capture and forces every output low. Output valid stays low after power-down is released until a fresh capture has completed.

Top module: `vcap_top`

## Requirements
- R1: With `edge_sel_i` = 1, pixel data and all control inputs are latched on the rising edge of `in_clk_i`.
- R2: With `edge_sel_i` = 0, pixel data and all control inputs are latched on the falling edge of `in_clk_i`.
- R3: With `pair_sel_i` = 0, each capture yields exactly one valid output pixel, taken from `even_i`; the value on `odd_i` never reaches the outputs.
- R4: With `pair_sel_i` = 1, each capture yields two valid output pixels on consecutive pixel clocks: the `even_i` value first, then the `odd_i` value.
- R5: `de_o`, `hsync_o`, `vsync_o` and `gp_o` carry the values captured on the same edge as the pixel, and in two-pixel mode they are identical on both pixels of a pair.
- R6: While `pd_ni` is low, no capture takes place, `valid_o` is low and every data and control output is 0.
- R7: After `pd_ni` rises, the first valid output pixel is the one captured on the first selected edge after the release; values present before the release never appear.
- R8: While `rst_ni` is low, `valid_o` and every data and control output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_clk_i | input | 1 | External input data clock |
| pix_clk_i | input | 1 | Output pixel clock: input rate, or twice it in two-pixel mode |
| pd_ni | input | 1 | Power-down, active low |
| edge_sel_i | input | 1 | Capture edge strap: 1 rising, 0 falling |
| pair_sel_i | input | 1 | Pixels per input clock strap: 0 one, 1 two |
| even_i | input | 24 | First (or only) pixel bus |
| odd_i | input | 24 | Second pixel bus, used in two-pixel mode |
| de_i | input | 1 | Data enable, high in active video |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| gp_i | input | 3 | General-purpose control bits |
| pix_o | output | 24 | Output pixel |
| de_o | output | 1 | Data enable for `pix_o` |
| hsync_o | output | 1 | Horizontal sync for `pix_o` |
| vsync_o | output | 1 | Vertical sync for `pix_o` |
| gp_o | output | 3 | Control bits for `pix_o` |
| valid_o | output | 1 | Output pixel valid |

## Verification
Every cycle, the assertions check that each capture bank advances and copies its inputs only when power is up, that power-down silences valid and data in the next pixel clock, that a pair's second pixel follows its first without a gap with the control bits held, and that single-pixel mode never emits a second pixel. Whether the correct edge was chosen, whether the odd bus stays hidden, the order of the pixel stream and the absence of stale data after power-down release can only be shown by the bench's scenarios. These drive different values around the rising and falling edges and compare the whole emitted stream against a reference queue.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  typedef struct packed {
    logic       de;
    logic       hs;
    logic       vs;
    logic [2:0] gp;
  } sync_t;
endpackage

// File: rtl/vcap_edge_reg.sv
module vcap_edge_reg
  import vcap_pkg::*;
#(
  parameter int unsigned PIX_W   = 24,
  parameter bit          FALLING = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic [PIX_W-1:0] even_i,
  input  logic [PIX_W-1:0] odd_i,
  input  sync_t            sync_i,
  output logic [PIX_W-1:0] even_q,
  output logic [PIX_W-1:0] odd_q,
  output sync_t            sync_q,
  output logic             tgl_q
);

  if (FALLING) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        even_q <= '0;
        odd_q  <= '0;
        sync_q <= '0;
        tgl_q  <= 1'b0;
      end else if (pd_ni) begin
        even_q <= even_i;
        odd_q  <= odd_i;
        sync_q <= sync_i;
        tgl_q  <= ~tgl_q;
      end
    end

    assert_fall_capture_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
      pd_ni |=> (even_q == $past(even_i) && sync_q == $past(sync_i)
                 && tgl_q != $past(tgl_q)));
    assert_fall_frozen_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !pd_ni |=> ($stable(tgl_q) && $stable(even_q) && $stable(odd_q)));
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        even_q <= '0;
        odd_q  <= '0;
        sync_q <= '0;
        tgl_q  <= 1'b0;
      end else if (pd_ni) begin
        even_q <= even_i;
        odd_q  <= odd_i;
        sync_q <= sync_i;
        tgl_q  <= ~tgl_q;
      end
    end

    assert_rise_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pd_ni |=> (even_q == $past(even_i) && sync_q == $past(sync_i)
                 && tgl_q != $past(tgl_q)));
    assert_rise_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pd_ni |=> ($stable(tgl_q) && $stable(even_q) && $stable(odd_q)));
  end

endmodule

// File: rtl/vcap_pair_out.sv
module vcap_pair_out
  import vcap_pkg::*;
#(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             pair_i,
  input  logic             tgl_i,
  input  logic [PIX_W-1:0] even_i,
  input  logic [PIX_W-1:0] odd_i,
  input  sync_t            sync_i,
  output logic [PIX_W-1:0] pix_o,
  output sync_t            sync_o,
  output logic             valid_o
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PIX_W-1:0] hold_q [DEPTH];
  sync_t            hold_sync_q;
  logic [IDX_W-1:0] rd_q;
  logic             seen_q;
  logic             pend_q;
  logic             valid_q;
  logic             fresh;

  // tgl_i changes once per capture; clocks are phase-related, no synchronizer
  assign fresh = (tgl_i != seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      pend_q      <= 1'b0;
      valid_q     <= 1'b0;
      rd_q        <= '0;
      hold_sync_q <= '0;
    end else if (!pd_ni) begin
      seen_q  <= tgl_i;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      rd_q    <= '0;
    end else if (fresh) begin
      seen_q      <= tgl_i;
      hold_sync_q <= sync_i;
      rd_q        <= '0;
      valid_q     <= 1'b1;
      pend_q      <= pair_i;
    end else if (pend_q) begin
      rd_q    <= IDX_W'(1);
      valid_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q[e] <= '0;
      end else if (pd_ni && fresh) begin
        hold_q[e] <= (e == 0) ? even_i : odd_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign pix_o   = valid_q ? hold_q[rd_q] : '0;
  assign sync_o  = valid_q ? hold_sync_q : '0;

  assert_pd_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (!valid_o && pix_o == '0 && sync_o == '0));
  assert_pair_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && pd_ni) |=> (valid_o && rd_q == IDX_W'(1)));
  assert_pair_ctrl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && pd_ni && !fresh) |=> $stable(sync_o));
  assert_single_no_second_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pair_i && !pend_q) |=> !(valid_o && rd_q != '0));

endmodule

// File: rtl/vcap_top.sv
module vcap_top
  import vcap_pkg::*;
#(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned GP_W  = 3
) (
  input  logic             rst_ni,
  input  logic             in_clk_i,
  input  logic             pix_clk_i,
  input  logic             pd_ni,
  input  logic             edge_sel_i,
  input  logic             pair_sel_i,
  input  logic [PIX_W-1:0] even_i,
  input  logic [PIX_W-1:0] odd_i,
  input  logic             de_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic [GP_W-1:0]  gp_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             de_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic [GP_W-1:0]  gp_o,
  output logic             valid_o
);

  localparam int unsigned NBANK = 2;  // index 0 falling, 1 rising

  sync_t            sync_in;
  sync_t            sync_out;
  logic [PIX_W-1:0] cap_even [NBANK];
  logic [PIX_W-1:0] cap_odd  [NBANK];
  sync_t            cap_sync [NBANK];
  logic             cap_tgl  [NBANK];

  assign sync_in = '{de: de_i, hs: hsync_i, vs: vsync_i, gp: gp_i};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vcap_edge_reg #(
      .PIX_W  (PIX_W),
      .FALLING(b == 0)
    ) u_bank (
      .clk_i (in_clk_i),
      .rst_ni(rst_ni),
      .pd_ni (pd_ni),
      .even_i(even_i),
      .odd_i (odd_i),
      .sync_i(sync_in),
      .even_q(cap_even[b]),
      .odd_q (cap_odd[b]),
      .sync_q(cap_sync[b]),
      .tgl_q (cap_tgl[b])
    );
  end

  logic [PIX_W-1:0] sel_even;
  logic [PIX_W-1:0] sel_odd;
  sync_t            sel_sync;
  logic             sel_tgl;

  always_comb begin
    sel_even = cap_even[edge_sel_i];
    sel_odd  = cap_odd[edge_sel_i];
    sel_sync = cap_sync[edge_sel_i];
    sel_tgl  = cap_tgl[edge_sel_i];
  end

  vcap_pair_out #(
    .PIX_W(PIX_W),
    .DEPTH(2)
  ) u_out (
    .clk_i  (pix_clk_i),
    .rst_ni (rst_ni),
    .pd_ni  (pd_ni),
    .pair_i (pair_sel_i),
    .tgl_i  (sel_tgl),
    .even_i (sel_even),
    .odd_i  (sel_odd),
    .sync_i (sel_sync),
    .pix_o  (pix_o),
    .sync_o (sync_out),
    .valid_o(valid_o)
  );

  assign de_o    = sync_out.de;
  assign hsync_o = sync_out.hs;
  assign vsync_o = sync_out.vs;
  assign gp_o    = sync_out.gp;

endmodule

// File: tb/vcap_top_tb.sv
module vcap_top_tb;

  logic        rst_ni = 1'b0;
  logic        pix_clk = 1'b0;
  logic        in_clk = 1'b0;
  logic        clk_run = 1'b0;
  logic        pd_ni = 1'b0;
  logic        edge_sel = 1'b1;
  logic        pair_sel = 1'b0;
  logic [23:0] even_d = '0;
  logic [23:0] odd_d = '0;
  logic [5:0]  sync_d = '0;   // {de, hsync, vsync, gp[2:0]}
  logic [23:0] pix_o;
  logic        de_o, hsync_o, vsync_o, valid_o;
  logic [2:0]  gp_o;

  int n_chk = 0;
  int n_fail = 0;
  int got_cnt = 0;
  logic need_next = 1'b0;
  logic [30:0] exp_q[$];  // {first_of_pair, sync[5:0], pix[23:0]}

  vcap_top u_dut (
    .rst_ni(rst_ni), .in_clk_i(in_clk), .pix_clk_i(pix_clk), .pd_ni(pd_ni),
    .edge_sel_i(edge_sel), .pair_sel_i(pair_sel),
    .even_i(even_d), .odd_i(odd_d),
    .de_i(sync_d[5]), .hsync_i(sync_d[4]), .vsync_i(sync_d[3]), .gp_i(sync_d[2:0]),
    .pix_o(pix_o), .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .gp_o(gp_o), .valid_o(valid_o)
  );

  always #5 pix_clk = ~pix_clk;

  // input clock: 100 MHz single, 50 MHz pair; edges stay 2 ns off pixel edges
  initial begin
    #2;
    forever begin
      #(pair_sel ? 10 : 5);
      if (clk_run || in_clk) in_clk = ~in_clk;
    end
  end

  // table: {edge, pair, count[5:0], seed[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {1'b1, 1'b0, 6'd12, 8'd11},
    {1'b0, 1'b0, 6'd10, 8'd22},
    {1'b1, 1'b1, 6'd9,  8'd33},
    {1'b0, 1'b1, 6'd8,  8'd44},
    {1'b1, 1'b1, 6'd1,  8'd55},
    {1'b0, 1'b0, 6'd1,  8'd66}
  };

  function automatic logic [23:0] ev_val(int s, int k, bit fall);
    return 24'(s * 24'h010203 + k * 24'h0A0B0C) ^ (fall ? 24'hF0F000 : 24'h0);
  endfunction
  function automatic logic [23:0] od_val(int s, int k, bit fall);
    return ~ev_val(s, k, fall) ^ 24'h5A5A5A;
  endfunction
  function automatic logic [5:0] sy_val(int s, int k, bit fall);
    return 6'(s + k * 7 + (fall ? 29 : 0));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // output monitor
  always @(negedge pix_clk) begin
    if (rst_ni) begin
      if (need_next) chk(valid_o, "R4 second pixel adjacent", {31'b0, valid_o}, 32'd1);
      need_next = 1'b0;
      if (valid_o) begin
        got_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 R7 unexpected pixel", {8'b0, pix_o}, 32'b0);
        end else begin
          logic [30:0] e;
          e = exp_q.pop_front();
          chk(pix_o == e[23:0], edge_sel ? "R1 R3 R4 pixel (rising)" : "R2 R3 R4 pixel (falling)",
              {8'b0, pix_o}, {8'b0, e[23:0]});
          chk({de_o, hsync_o, vsync_o, gp_o} == e[29:24], "R5 control with pixel",
              {26'b0, de_o, hsync_o, vsync_o, gp_o}, {26'b0, e[29:24]});
          need_next = e[30];
        end
      end
    end
  end

  task automatic push_cap(int s, int k);
    bit f;
    f = !edge_sel;
    exp_q.push_back({pair_sel, sy_val(s, k, f), ev_val(s, k, f)});
    if (pair_sel) exp_q.push_back({1'b0, sy_val(s, k, f), od_val(s, k, f)});
  endtask

  task automatic drive_set(int s, int k, bit fall);
    even_d = ev_val(s, k, fall);
    odd_d  = od_val(s, k, fall);
    sync_d = sy_val(s, k, fall);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #23;
    chk(valid_o == 1'b0 && pix_o == '0, "R8 reset outputs", {7'b0, valid_o, pix_o}, 32'b0);
    chk({de_o, hsync_o, vsync_o, gp_o} == '0, "R8 reset controls",
        {26'b0, de_o, hsync_o, vsync_o, gp_o}, 32'b0);
    #4 rst_ni = 1'b1;

    for (int v = 0; v < 6; v++) begin
      int s, n;
      edge_sel = VEC[v][15];
      pair_sel = VEC[v][14];
      n = int'(VEC[v][13:8]);
      s = int'(VEC[v][7:0]);
      got_cnt = 0;
      // stale values that must never appear (R7)
      even_d = 24'hBAD000 | 24'(v); odd_d = 24'hBAD100; sync_d = 6'h3F;
      clk_run = 1'b1;
      repeat (4) @(posedge pix_clk);
      even_d = 24'hBAD200 | 24'(v);
      repeat (2) @(negedge pix_clk);
      chk(valid_o == 1'b0 && pix_o == '0 && de_o == 1'b0, "R6 power-down idle",
          {7'b0, valid_o, pix_o}, 32'b0);
      @(negedge in_clk); #1;
      pd_ni = 1'b1;
      drive_set(s, 0, 1'b0);
      @(posedge in_clk); #1;
      drive_set(s, 0, 1'b1);
      push_cap(s, 0);
      for (int k = 1; k < n; k++) begin
        @(negedge in_clk); #1;
        drive_set(s, k, 1'b0);
        @(posedge in_clk); #1;
        drive_set(s, k, 1'b1);
        push_cap(s, k);
      end
      @(negedge in_clk); #1;
      clk_run = 1'b0;
      repeat (6) @(posedge pix_clk);
      #5;
      chk(exp_q.size() == 0, "R3 R4 stream drained", exp_q.size(), 32'd0);
      chk(got_cnt == (pair_sel ? 2 * n : n), pair_sel ? "R4 pixel count" : "R3 pixel count",
          got_cnt, pair_sel ? 2 * n : n);
      exp_q.delete();
      pd_ni = 1'b0;
    end

    // R6: running clock with changing inputs under power-down
    clk_run = 1'b1;
    for (int i = 0; i < 6; i++) begin
      even_d = 24'h00F00 + 24'(i);
      sync_d = 6'(i + 40);
      @(negedge pix_clk);
      chk(valid_o == 1'b0 && pix_o == '0 && {de_o, hsync_o, vsync_o, gp_o} == '0,
          "R6 no output while powered down", {7'b0, valid_o, pix_o}, 32'b0);
    end
    clk_run = 1'b0;
    repeat (4) @(posedge pix_clk);
    finish_run();
  end

endmodule